// File: doc/BRIEF.md
# Re-reference interval set replacement

This block keeps the replacement metadata of one set of a set-associative last-level cache. Each way carries a 2-bit predicted re-reference value, a valid bit, a reuse bit, a prefetch flag and the 14-bit signature of the access that filled it. Tag matching and data storage live elsewhere. The surrounding cache tells the block about hits and fills, and asks it for a victim when it needs one.

On a victim request the block first takes any invalid way. If every way is valid, it looks for a way predicted for distant re-reference. When no way qualifies, it ages the whole set by one step per clock until one does. The chosen way is announced with a one-cycle strobe. When the victim held a valid line, its signature, prefetch flag and reuse bit go out in the same cycle, so that an external predictor can learn from the eviction. That predictor supplies the insertion value with every fill.

A hit normally promotes a line to the nearest re-reference value. The first demand touch of a line that a prefetch brought in is handled differently: it only clears the prefetch flag and leaves the value unchanged. This stops an accurate prefetch from being kept long after it has served its purpose.

Top module: `rrip_set_repl`

## Requirements
- R1: After reset no victim strobe or training strobe is raised, all ways are invalid, and a victim request picks the lowest-numbered invalid way, with `train_vld` low.
- R2: When every way is valid, the victim is the lowest-numbered way whose value is 3 (distant). Values run 0 immediate, 1 intermediate, 2 far, 3 distant.
- R3: A victim request sampled at a clock edge with no invalid way and a maximum set value of m gives `vic_vld` high in the cycle that follows the (3-m)+1-th edge. Each aging round adds one to the value of every valid way and takes one clock.
- R4: A hit on a valid way sets its reuse bit and sets its value to 0, unless R5 applies.
- R5: A hit of type demand (`hit_type` 2'b00) on a way whose prefetch flag is set clears the flag, sets the reuse bit and leaves the value unchanged. Later hits then promote the line as in R4.
- R6: A fill writes the insertion value `fill_ins`, clears the reuse bit, sets the prefetch flag exactly when `fill_type` is 2'b01 (prefetch; 2'b00 is demand and 2'b10 is writeback), stores `fill_sig`, and marks the way valid.
- R7: `train_vld` is high only in a `vic_vld` cycle whose victim was valid. In that cycle `train_sig`, `train_pf` and `train_reuse` carry that way's stored signature, prefetch flag and reuse bit.
- R8: A hit on an invalid way has no effect. The way stays invalid and is still taken as a victim without training.
- R9: `vic_vld` is high for exactly one cycle per accepted request. A request that arrives while a search is running, or in its strobe cycle, is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hit_vld | input | 1 | A lookup hit the way given by hit_way |
| hit_way | input | WAY_W | Way that hit |
| hit_type | input | 2 | Access type of the hit: 00 demand, 01 prefetch, 10 writeback |
| fill_vld | input | 1 | Install a new line in fill_way |
| fill_way | input | WAY_W | Way being filled |
| fill_type | input | 2 | Access type of the fill, same encoding as hit_type |
| fill_ins | input | 2 | Insertion re-reference value from the predictor |
| fill_sig | input | SIG_W | Signature of the access causing the fill |
| vic_req | input | 1 | Ask for a victim way |
| vic_vld | output | 1 | One-cycle strobe: vic_way is the chosen victim |
| vic_way | output | WAY_W | Chosen victim way |
| train_vld | output | 1 | A valid line is being evicted; training fields are meaningful |
| train_sig | output | SIG_W | Signature stored with the evicted line |
| train_pf | output | 1 | Prefetch flag of the evicted line |
| train_reuse | output | 1 | Reuse bit of the evicted line |

## Verification
The assertions assume that no hit and no fill arrive while a victim search is running. Aging then acts on a set that nothing else touches. One assertion states this assumption as a check on the inputs. The bench keeps to it by issuing a request, waiting until its model says the strobe has passed, and only then driving hits or fills. Hits and fills are never issued in the same cycle. The bench's reference model does all aging rounds of a search at once, at the edge that accepts the request. That is only equivalent to the design's round-per-clock aging because the set is quiet during the search.

// File: rtl/rrip_pkg.sv
package rrip_pkg;
  localparam int RV_W = 2;
  localparam logic [RV_W-1:0] RV_NEAR    = 2'd0;
  localparam logic [RV_W-1:0] RV_DISTANT = 2'd3;

  typedef enum logic [1:0] {
    ACC_DEMAND    = 2'd0,
    ACC_PREFETCH  = 2'd1,
    ACC_WRITEBACK = 2'd2
  } acc_t;

  // One aging step; a distant value stays distant.
  function automatic logic [RV_W-1:0] rv_age(input logic [RV_W-1:0] v);
    return (v == RV_DISTANT) ? v : v + 1'b1;
  endfunction

  function automatic logic is_prefetch(input logic [1:0] t);
    return t == ACC_PREFETCH;
  endfunction

  function automatic logic is_demand(input logic [1:0] t);
    return t == ACC_DEMAND;
  endfunction
endpackage

// File: rtl/rrip_way_entry.sv
module rrip_way_entry
  import rrip_pkg::*;
#(
  parameter int SIG_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fill_en,
  input  logic [RV_W-1:0]  fill_ins,
  input  logic             fill_pf,
  input  logic [SIG_W-1:0] fill_sig,
  input  logic             hit_en,
  input  logic             hit_demand,
  input  logic             age_en,
  output logic             valid_o,
  output logic [RV_W-1:0]  rv_o,
  output logic             pf_o,
  output logic             reuse_o,
  output logic [SIG_W-1:0] sig_o
);
  logic first_pf_touch;
  assign first_pf_touch = pf_o && hit_demand;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_o <= 1'b0;
      rv_o    <= RV_DISTANT;
      pf_o    <= 1'b0;
      reuse_o <= 1'b0;
      sig_o   <= '0;
    end else if (fill_en) begin
      valid_o <= 1'b1;
      rv_o    <= fill_ins;
      pf_o    <= fill_pf;
      reuse_o <= 1'b0;
      sig_o   <= fill_sig;
    end else if (hit_en && valid_o) begin
      reuse_o <= 1'b1;
      if (first_pf_touch) pf_o <= 1'b0;
      else                rv_o <= RV_NEAR;
    end else if (age_en && valid_o) begin
      rv_o <= rv_age(rv_o);
    end
  end
endmodule

// File: rtl/rrip_victim_pick.sv
module rrip_victim_pick
  import rrip_pkg::*;
#(
  parameter int WAYS  = 8,
  parameter int WAY_W = 3
) (
  input  logic [WAYS-1:0]           valid,
  input  logic [WAYS-1:0][RV_W-1:0] rv,
  output logic                      inv_found,
  output logic [WAY_W-1:0]          inv_way,
  output logic                      dist_found,
  output logic [WAY_W-1:0]          dist_way
);
  // Scan from the top down so the lowest index is written last and wins.
  always_comb begin
    inv_found  = 1'b0;
    inv_way    = '0;
    dist_found = 1'b0;
    dist_way   = '0;
    for (int i = WAYS - 1; i >= 0; i--) begin
      if (!valid[i]) begin
        inv_found = 1'b1;
        inv_way   = WAY_W'(i);
      end
      if (valid[i] && rv[i] == RV_DISTANT) begin
        dist_found = 1'b1;
        dist_way   = WAY_W'(i);
      end
    end
  end
endmodule

// File: rtl/rrip_search_ctl.sv
module rrip_search_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic found,
  output logic searching,
  output logic fire,
  output logic age_en
);
  assign fire   = searching && found;
  assign age_en = searching && !found;

  always_ff @(posedge clk) begin
    if (!rst_n)                  searching <= 1'b0;
    else if (fire)               searching <= 1'b0;
    else if (req && !searching)  searching <= 1'b1;
  end
endmodule

// File: rtl/rrip_set_repl.sv
module rrip_set_repl
  import rrip_pkg::*;
#(
  parameter int WAYS  = 8,
  parameter int SIG_W = 14,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hit_vld,
  input  logic [WAY_W-1:0] hit_way,
  input  logic [1:0]       hit_type,
  input  logic             fill_vld,
  input  logic [WAY_W-1:0] fill_way,
  input  logic [1:0]       fill_type,
  input  logic [1:0]       fill_ins,
  input  logic [SIG_W-1:0] fill_sig,
  input  logic             vic_req,
  output logic             vic_vld,
  output logic [WAY_W-1:0] vic_way,
  output logic             train_vld,
  output logic [SIG_W-1:0] train_sig,
  output logic             train_pf,
  output logic             train_reuse
);
  logic [WAYS-1:0]             way_valid;
  logic [WAYS-1:0][RV_W-1:0]   way_rv;
  logic [WAYS-1:0]             way_pf;
  logic [WAYS-1:0]             way_reuse;
  logic [WAYS-1:0][SIG_W-1:0]  way_sig;

  logic             inv_found, dist_found;
  logic [WAY_W-1:0] inv_way, dist_way;
  logic             searching, fire, age_en;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    rrip_way_entry #(.SIG_W(SIG_W)) u_entry (
      .clk       (clk),
      .rst_n     (rst_n),
      .fill_en   (fill_vld && fill_way == WAY_W'(w)),
      .fill_ins  (fill_ins),
      .fill_pf   (is_prefetch(fill_type)),
      .fill_sig  (fill_sig),
      .hit_en    (hit_vld && hit_way == WAY_W'(w)),
      .hit_demand(is_demand(hit_type)),
      .age_en    (age_en),
      .valid_o   (way_valid[w]),
      .rv_o      (way_rv[w]),
      .pf_o      (way_pf[w]),
      .reuse_o   (way_reuse[w]),
      .sig_o     (way_sig[w])
    );
  end

  rrip_victim_pick #(.WAYS(WAYS), .WAY_W(WAY_W)) u_pick (
    .valid     (way_valid),
    .rv        (way_rv),
    .inv_found (inv_found),
    .inv_way   (inv_way),
    .dist_found(dist_found),
    .dist_way  (dist_way)
  );

  rrip_search_ctl u_ctl (
    .clk      (clk),
    .rst_n    (rst_n),
    .req      (vic_req),
    .found    (inv_found || dist_found),
    .searching(searching),
    .fire     (fire),
    .age_en   (age_en)
  );

  assign vic_vld     = fire;
  assign vic_way     = inv_found ? inv_way : dist_way;
  assign train_vld   = fire && !inv_found;
  assign train_sig   = way_sig[vic_way];
  assign train_pf    = way_pf[vic_way];
  assign train_reuse = way_reuse[vic_way];
endmodule

// File: rtl/rrip_set_repl_chk.sv
module rrip_set_repl_chk #(
  parameter int WAYS  = 8,
  parameter int WAY_W = 3
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  hit_vld,
  input logic [WAY_W-1:0]      hit_way,
  input logic [1:0]            hit_type,
  input logic                  fill_vld,
  input logic [WAY_W-1:0]      fill_way,
  input logic                  vic_vld,
  input logic [WAY_W-1:0]      vic_way,
  input logic                  train_vld,
  input logic                  searching,
  input logic [WAYS-1:0]       way_valid,
  input logic [WAYS-1:0][1:0]  way_rv,
  input logic [WAYS-1:0]       way_pf,
  input logic [WAYS-1:0]       way_reuse
);
  logic             promote_q, pfclr_q, fill_q;
  logic [WAY_W-1:0] hway_q, fway_q;
  logic [1:0]       rv_q;

  function automatic logic lower_distant(input logic [WAYS-1:0][1:0] rv,
                                         input logic [WAYS-1:0] vld,
                                         input logic [WAY_W-1:0] way);
    logic r;
    r = 1'b0;
    for (int i = 0; i < WAYS; i++)
      if (WAY_W'(i) < way && vld[i] && rv[i] == 2'd3) r = 1'b1;
    return r;
  endfunction

  function automatic logic lower_invalid(input logic [WAYS-1:0] vld,
                                         input logic [WAY_W-1:0] way);
    logic r;
    r = 1'b0;
    for (int i = 0; i < WAYS; i++)
      if (WAY_W'(i) < way && !vld[i]) r = 1'b1;
    return r;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      promote_q <= 1'b0;
      pfclr_q   <= 1'b0;
      fill_q    <= 1'b0;
      hway_q    <= '0;
      fway_q    <= '0;
      rv_q      <= '0;
    end else begin
      promote_q <= hit_vld && !fill_vld && way_valid[hit_way]
                   && !(way_pf[hit_way] && hit_type == 2'd0);
      pfclr_q   <= hit_vld && !fill_vld && way_valid[hit_way]
                   && way_pf[hit_way] && hit_type == 2'd0;
      fill_q    <= fill_vld;
      hway_q    <= hit_way;
      fway_q    <= fill_way;
      rv_q      <= way_rv[hit_way];
    end
  end

  assert_invalid_first_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (vic_vld && !train_vld) |-> (!way_valid[vic_way] && !lower_invalid(way_valid, vic_way)));

  assert_victim_distant_R2: assert property (@(posedge clk) disable iff (!rst_n)
    train_vld |-> (way_rv[vic_way] == 2'd3 && !lower_distant(way_rv, way_valid, vic_way)
                   && way_valid == {WAYS{1'b1}}));

  // R3: aging assumes a quiet set during the search.
  assert_quiet_search_R3: assert property (@(posedge clk) disable iff (!rst_n)
    searching |-> (!hit_vld && !fill_vld));

  assert_hit_promote_R4: assert property (@(posedge clk) disable iff (!rst_n)
    promote_q |-> (way_rv[hway_q] == 2'd0 && way_reuse[hway_q]));

  assert_pf_first_touch_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pfclr_q |-> (way_rv[hway_q] == rv_q && !way_pf[hway_q] && way_reuse[hway_q]));

  assert_fill_install_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fill_q |-> (way_valid[fway_q] && !way_reuse[fway_q]));

  assert_train_in_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
    train_vld |-> vic_vld);

  assert_strobe_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    vic_vld |=> !vic_vld);
endmodule

bind rrip_set_repl rrip_set_repl_chk #(.WAYS(WAYS), .WAY_W(WAY_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .hit_vld  (hit_vld),
  .hit_way  (hit_way),
  .hit_type (hit_type),
  .fill_vld (fill_vld),
  .fill_way (fill_way),
  .vic_vld  (vic_vld),
  .vic_way  (vic_way),
  .train_vld(train_vld),
  .searching(searching),
  .way_valid(way_valid),
  .way_rv   (way_rv),
  .way_pf   (way_pf),
  .way_reuse(way_reuse)
);

// File: tb/rrip_set_repl_test.sv
module rrip_set_repl_test;
  localparam int WAYS  = 8;
  localparam int SIG_W = 14;
  localparam int WAY_W = 3;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             hit_vld = 1'b0;
  logic [WAY_W-1:0] hit_way = '0;
  logic [1:0]       hit_type = '0;
  logic             fill_vld = 1'b0;
  logic [WAY_W-1:0] fill_way = '0;
  logic [1:0]       fill_type = '0;
  logic [1:0]       fill_ins = '0;
  logic [SIG_W-1:0] fill_sig = '0;
  logic             vic_req = 1'b0;
  logic             vic_vld;
  logic [WAY_W-1:0] vic_way;
  logic             train_vld;
  logic [SIG_W-1:0] train_sig;
  logic             train_pf;
  logic             train_reuse;

  rrip_set_repl #(.WAYS(WAYS), .SIG_W(SIG_W)) uut (
    .clk(clk), .rst_n(rst_n),
    .hit_vld(hit_vld), .hit_way(hit_way), .hit_type(hit_type),
    .fill_vld(fill_vld), .fill_way(fill_way), .fill_type(fill_type),
    .fill_ins(fill_ins), .fill_sig(fill_sig),
    .vic_req(vic_req), .vic_vld(vic_vld), .vic_way(vic_way),
    .train_vld(train_vld), .train_sig(train_sig), .train_pf(train_pf),
    .train_reuse(train_reuse)
  );

  always #5 clk = ~clk;

  int    n_cmp = 0;
  int    n_bad = 0;
  int    cycles = 0;
  string cur_req = "R1";

  // Reference model of the set.
  bit m_valid[WAYS];
  int m_rv[WAYS];
  bit m_pf[WAYS];
  bit m_reuse[WAYS];
  int m_sig[WAYS];
  bit m_pending;
  int m_cnt;
  int m_vway;
  bit m_train;
  int m_tsig;
  bit m_tpf, m_treuse;

  task automatic check(input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      for (int i = 0; i < WAYS; i++) begin
        m_valid[i] = 0; m_rv[i] = 3; m_pf[i] = 0; m_reuse[i] = 0; m_sig[i] = 0;
      end
      m_pending = 0; m_cnt = 0;
    end else begin
      if (m_pending) begin
        if (m_cnt == 0) m_pending = 0;
        else m_cnt--;
      end else if (vic_req) begin
        int inv;
        inv = -1;
        for (int i = WAYS - 1; i >= 0; i--) if (!m_valid[i]) inv = i;
        m_pending = 1;
        if (inv >= 0) begin
          m_vway = inv; m_train = 0; m_cnt = 0;
        end else begin
          int mx;
          mx = 0;
          for (int i = 0; i < WAYS; i++) if (m_rv[i] > mx) mx = m_rv[i];
          m_cnt = 3 - mx;
          for (int i = 0; i < WAYS; i++) m_rv[i] += m_cnt;
          m_vway = -1;
          for (int i = WAYS - 1; i >= 0; i--) if (m_rv[i] == 3) m_vway = i;
          m_train = 1;
          m_tsig = m_sig[m_vway]; m_tpf = m_pf[m_vway]; m_treuse = m_reuse[m_vway];
        end
      end
      if (fill_vld) begin
        m_valid[fill_way] = 1; m_rv[fill_way] = fill_ins;
        m_pf[fill_way] = (fill_type == 2'b01); m_reuse[fill_way] = 0;
        m_sig[fill_way] = fill_sig;
      end else if (hit_vld && m_valid[hit_way]) begin
        m_reuse[hit_way] = 1;
        if (m_pf[hit_way] && hit_type == 2'b00) m_pf[hit_way] = 0;
        else m_rv[hit_way] = 0;
      end
    end
  end

  // Compare on every clock, away from the active edge.
  always @(negedge clk) begin
    if (rst_n) begin
      bit ev;
      ev = m_pending && m_cnt == 0;
      check(cur_req, "vic_vld", vic_vld, ev);
      if (ev) begin
        check(cur_req, "vic_way", vic_way, m_vway);
        check("R7", "train_vld", train_vld, m_train);
        if (m_train) begin
          check("R7", "train_sig", train_sig, m_tsig);
          check("R7", "train_pf", train_pf, m_tpf);
          check("R7", "train_reuse", train_reuse, m_treuse);
        end
      end else begin
        check("R7", "train_vld idle", train_vld, 0);
      end
    end
  end

  task automatic do_fill(input int w, input int ins, input int t, input int s);
    @(negedge clk);
    fill_vld = 1; fill_way = WAY_W'(w); fill_ins = 2'(ins); fill_type = 2'(t);
    fill_sig = SIG_W'(s);
    @(negedge clk);
    fill_vld = 0;
  endtask

  task automatic do_hit(input int w, input int t);
    @(negedge clk);
    hit_vld = 1; hit_way = WAY_W'(w); hit_type = 2'(t);
    @(negedge clk);
    hit_vld = 0;
  endtask

  task automatic do_victim(output int w);
    @(negedge clk);
    vic_req = 1;
    @(negedge clk);
    vic_req = 0;
    w = m_vway;
    while (m_pending) @(negedge clk);
  endtask

  task automatic wait_latency(input string req, input int exp_edges);
    int n;
    n = 0;
    @(negedge clk);
    vic_req = 1;
    @(negedge clk);
    vic_req = 0;
    n = 1;
    while (!vic_vld && n < 10) begin
      @(negedge clk);
      n++;
    end
    check(req, "strobe latency", n, exp_edges);
    while (m_pending) @(negedge clk);
  endtask

  initial begin
    int w;
    void'($urandom(7));
    repeat (3) @(negedge clk);
    cur_req = "R1";
    check("R1", "vic_vld in reset", vic_vld, 0);
    check("R1", "train_vld in reset", train_vld, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    do_victim(w);
    check("R1", "first victim", w, 0);

    // R8: hit on invalid way 3, then find it still invalid.
    cur_req = "R8";
    for (int i = 0; i < WAYS; i++) if (i != 3) do_fill(i, 2, 0, 100 + i);
    do_hit(3, 0);
    do_victim(w);
    check("R8", "invalid way kept", w, 3);

    // R6/R2: fill remaining, victim is lowest way at 3.
    cur_req = "R6";
    do_fill(3, 1, 2, 333);
    do_fill(5, 3, 0, 555);
    do_fill(6, 3, 0, 666);
    cur_req = "R2";
    do_victim(w);
    check("R2", "lowest distant", w, 5);
    do_fill(5, 0, 0, 5005);

    // R3: max value 2 -> one aging round -> strobe after 2 edges.
    cur_req = "R3";
    do_fill(6, 1, 0, 606);
    wait_latency("R3", 2);
    do_fill(0, 0, 0, 10); do_fill(1, 0, 0, 11); do_fill(2, 0, 0, 12);
    do_fill(3, 0, 0, 13); do_fill(4, 0, 0, 14); do_fill(5, 0, 0, 15);
    do_fill(6, 0, 0, 16); do_fill(7, 0, 0, 17);
    wait_latency("R3", 4);

    // R4: hits promote and set reuse.
    cur_req = "R4";
    do_hit(0, 0); do_hit(2, 2);
    do_victim(w);
    check("R4", "non-promoted victim", w, 1);
    do_fill(1, 3, 0, 4321);

    // R5: prefetch fill, first demand touch keeps value 3.
    cur_req = "R5";
    do_fill(1, 3, 1, 777);
    do_hit(1, 0);
    do_victim(w);
    check("R5", "first touch not promoted", w, 1);
    do_fill(1, 3, 1, 778);
    do_hit(1, 0);
    do_hit(1, 0);
    do_fill(3, 3, 0, 900);
    do_victim(w);
    check("R5", "second touch promoted", w, 3);
    do_fill(3, 2, 2, 901);

    // R9: request held high across several searches.
    cur_req = "R9";
    @(negedge clk);
    vic_req = 1;
    repeat (12) @(negedge clk);
    vic_req = 0;
    while (m_pending) @(negedge clk);

    // Mixed traffic.
    cur_req = "R2";
    for (int k = 0; k < 400; k++) begin
      int op;
      op = int'($urandom_range(0, 2));
      if (op == 0) do_fill(int'($urandom_range(0, WAYS - 1)), int'($urandom_range(0, 3)),
                           int'($urandom_range(0, 2)), int'($urandom_range(0, 16383)));
      else if (op == 1) do_hit(int'($urandom_range(0, WAYS - 1)), int'($urandom_range(0, 2)));
      else begin
        do_victim(w);
        do_fill(w, int'($urandom_range(0, 3)), int'($urandom_range(0, 2)),
                int'($urandom_range(0, 16383)));
      end
    end
    repeat (3) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    wait (cycles > 100000);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule